// File: doc/BRIEF.md
# Subtractive GCD Controller-Datapath Unit

This block computes the greatest common divisor of two unsigned operands by repeated subtraction. It is split into a datapath, which holds one register per program variable, input multiplexers, one subtractor per direction and the comparison flags, and a finite-state controller. The controller has one state for each statement of the algorithm. It reads only the datapath flags and drives only load enables and multiplexer selects, so exactly one statement executes per clock cycle.

A caller places two operands on the inputs and pulses `start` while the unit is idle or finished. The unit then walks the loop: test for inequality, test which operand is larger, subtract the smaller from the larger, and repeat. When the operands are equal it raises `done`. `result` holds the answer until the next start. If either operand is zero the loop is skipped and the other operand is returned, so the loop always terminates.

States: `ST_IDLE` (waiting), `ST_ZCHK` (zero-operand test), `ST_TEST_NE` (loop test), `ST_TEST_GT` (branch test), `ST_SUB_A` (x := x − y), `ST_SUB_B` (y := y − x), `ST_DONE` (result held). Transitions:
- IDLE→ZCHK on start, with both registers loaded.
- DONE→ZCHK on start, with both registers loaded.
- ZCHK→DONE if either register is zero. When x is zero, x is loaded from y in the same step.
- ZCHK→TEST_NE otherwise.
- TEST_NE→TEST_GT when x≠y.
- TEST_NE→DONE when x=y.
- TEST_GT→SUB_A when x>y.
- TEST_GT→SUB_B otherwise.
- SUB_A→TEST_NE and SUB_B→TEST_NE unconditionally.

Top module: `sgcd_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the unit returns to idle: after that edge `done` is 0 and `result` is 0.
- R2: A `start` seen at a clock edge while idle or finished loads both operands from `opnd_a` and `opnd_b` at that edge and begins a new computation.
- R3: For two nonzero operands, `result` equals their greatest common divisor when `done` is 1.
- R4: If either operand is zero, `result` is the other operand (0 when both are zero), and `done` rises at the second clock edge after the start edge.
- R5: For nonzero operands needing n subtractions, `done` rises at the clock edge 3+3n edges after the start edge: one edge for load, one for the zero test, three per iteration and one for the final equality test.
- R6: In a subtract step, the larger register is replaced by larger minus smaller and the other register is unchanged. The x register is reduced when x > y; otherwise the y register is reduced.
- R7: `start` has no effect while a computation is in progress. The result and the cycle count are those of the operands loaded first.
- R8: Once `done` is 1, it stays 1 and `result` stays unchanged until a `start` is seen.
- R9: Every subtract state is followed by the loop test, and the branch test is always followed by a subtract state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a computation (honoured when idle or finished) |
| opnd_a | input | W | First unsigned operand |
| opnd_b | input | W | Second unsigned operand |
| result | output | W | GCD, valid while done is 1 |
| done | output | 1 | Computation finished |

## Verification
Two functions can meet in one cycle: a new `start` accepted in the finished state, while `done` and the held result from the previous run are still on the outputs. The bench provokes this by issuing every run back to back from the finished state. It then judges that `done` falls and that the new result and cycle count match the new operands alone. It also pulses `start` with different operands in the middle of a long run. It then judges that the busy states ignore it by checking the first operands' answer and cycle count.

// File: rtl/sgcd_pkg.sv
package sgcd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ZCHK,
        ST_TEST_NE,
        ST_TEST_GT,
        ST_SUB_A,
        ST_SUB_B,
        ST_DONE
    } gcd_state_t;

    // source for the x register
    typedef enum logic [1:0] {
        XSEL_OPND,
        XSEL_DIFF,
        XSEL_OTHER
    } xsel_t;

    // source for the y register
    typedef enum logic {
        YSEL_OPND,
        YSEL_DIFF
    } ysel_t;

endpackage

// File: rtl/sgcd_datapath.sv
module sgcd_datapath #(
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [W-1:0]         opnd_a,
    input  logic [W-1:0]         opnd_b,
    input  logic                 ld_x,
    input  logic                 ld_y,
    input  sgcd_pkg::xsel_t      xsel,
    input  sgcd_pkg::ysel_t      ysel,
    output logic [W-1:0]         x_q,
    output logic [W-1:0]         y_q,
    output logic                 f_ne,
    output logic                 f_gt,
    output logic                 f_xzero,
    output logic                 f_yzero
);
    import sgcd_pkg::*;

    logic [W-1:0] diff_xy;
    logic [W-1:0] diff_yx;
    logic [W-1:0] x_d;
    logic [W-1:0] y_d;

    // one functional unit per operator
    assign diff_xy = x_q - y_q;
    assign diff_yx = y_q - x_q;

    assign f_ne    = (x_q != y_q);
    assign f_gt    = (x_q > y_q);
    assign f_xzero = (x_q == '0);
    assign f_yzero = (y_q == '0);

    always_comb begin
        unique case (xsel)
            XSEL_OPND:  x_d = opnd_a;
            XSEL_DIFF:  x_d = diff_xy;
            XSEL_OTHER: x_d = y_q;
            default:    x_d = x_q;
        endcase
    end

    always_comb begin
        unique case (ysel)
            YSEL_OPND: y_d = opnd_b;
            YSEL_DIFF: y_d = diff_yx;
            default:   y_d = y_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= '0;
            y_q <= '0;
        end else begin
            if (ld_x) x_q <= x_d;
            if (ld_y) y_q <= y_d;
        end
    end

endmodule

// File: rtl/sgcd_ctrl.sv
module sgcd_ctrl (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    f_ne,
    input  logic                    f_gt,
    input  logic                    f_xzero,
    input  logic                    f_yzero,
    output logic                    ld_x,
    output logic                    ld_y,
    output sgcd_pkg::xsel_t         xsel,
    output sgcd_pkg::ysel_t         ysel,
    output logic                    fin,
    output sgcd_pkg::gcd_state_t    state
);
    import sgcd_pkg::*;

    gcd_state_t state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // transitions driven by datapath flags only
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_DONE: if (start) state_nx = ST_ZCHK;
            ST_ZCHK:          state_nx = (f_xzero || f_yzero) ? ST_DONE : ST_TEST_NE;
            ST_TEST_NE:       state_nx = f_ne ? ST_TEST_GT : ST_DONE;
            ST_TEST_GT:       state_nx = f_gt ? ST_SUB_A : ST_SUB_B;
            ST_SUB_A,
            ST_SUB_B:         state_nx = ST_TEST_NE;
            default:          state_nx = ST_IDLE;
        endcase
    end

    // register-update actions issued per state
    always_comb begin
        ld_x = 1'b0;
        ld_y = 1'b0;
        xsel = XSEL_OPND;
        ysel = YSEL_OPND;
        fin  = (state == ST_DONE);
        unique case (state)
            ST_IDLE, ST_DONE: begin
                ld_x = start;
                ld_y = start;
            end
            ST_ZCHK: begin
                ld_x = f_xzero;
                xsel = XSEL_OTHER;
            end
            ST_SUB_A: begin
                ld_x = 1'b1;
                xsel = XSEL_DIFF;
            end
            ST_SUB_B: begin
                ld_y = 1'b1;
                ysel = YSEL_DIFF;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sgcd_unit.sv
module sgcd_unit #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] result,
    output logic         done
);
    import sgcd_pkg::*;

    logic         ld_x, ld_y;
    xsel_t        xsel;
    ysel_t        ysel;
    logic [W-1:0] x_q, y_q;
    logic         f_ne, f_gt, f_xzero, f_yzero;
    gcd_state_t   state;

    sgcd_datapath #(.W(W)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .ld_x    (ld_x),
        .ld_y    (ld_y),
        .xsel    (xsel),
        .ysel    (ysel),
        .x_q     (x_q),
        .y_q     (y_q),
        .f_ne    (f_ne),
        .f_gt    (f_gt),
        .f_xzero (f_xzero),
        .f_yzero (f_yzero)
    );

    sgcd_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .f_ne    (f_ne),
        .f_gt    (f_gt),
        .f_xzero (f_xzero),
        .f_yzero (f_yzero),
        .ld_x    (ld_x),
        .ld_y    (ld_y),
        .xsel    (xsel),
        .ysel    (ysel),
        .fin     (done),
        .state   (state)
    );

    assign result = x_q;

endmodule

// File: rtl/sgcd_checker.sv
module sgcd_checker #(
    parameter int W = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 done,
    input logic [W-1:0]         result,
    input sgcd_pkg::gcd_state_t state,
    input logic [W-1:0]         x_q,
    input logic [W-1:0]         y_q
);
    import sgcd_pkg::*;

    assert_reset_clears_R1: assert property (@(posedge clk)
        $past(rst) |-> (!done && result == '0));

    assert_sub_x_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SUB_A) |=> (x_q == $past(x_q) - $past(y_q)) && $stable(y_q));

    assert_sub_y_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SUB_B) |=> (y_q == $past(y_q) - $past(x_q)) && $stable(x_q));

    assert_branch_pick_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TEST_GT && x_q > y_q) |=> (state == ST_SUB_A));

    assert_busy_ignores_start_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SUB_A || state == ST_SUB_B) |=> (state == ST_TEST_NE));

    assert_branch_to_sub_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TEST_GT) |=> (state == ST_SUB_A || state == ST_SUB_B));

    assert_done_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(result)));

endmodule

bind sgcd_unit sgcd_checker #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .done   (done),
    .result (result),
    .state  (state),
    .x_q    (x_q),
    .y_q    (y_q)
);

// File: tb/sgcd_unit_bench.sv
module sgcd_unit_bench;

    localparam int W      = 4;
    localparam int CLK_P  = 10;
    localparam int MAXCYC = 1000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [W-1:0] result;
    logic         done;

    int checks = 0;
    int errors = 0;

    sgcd_unit #(.W(W)) u_sgcd_unit (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .result (result),
        .done   (done)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic int ref_gcd(input int p, input int q);
        int t;
        while (q != 0) begin
            t = p % q;
            p = q;
            q = t;
        end
        return p;
    endfunction

    function automatic int sub_count(input int p, input int q);
        int n = 0;
        while (p != q) begin
            if (p > q) p = p - q;
            else       q = q - p;
            n++;
        end
        return n;
    endfunction

    function automatic int exp_cycles(input int p, input int q);
        if (p == 0 || q == 0) return 2;
        return 3 + 3 * sub_count(p, q);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // poke > 0: pulse start with other operands at that cycle of the run
    task automatic run(input int p, input int q, input int poke, output int cyc);
        @(negedge clk);
        opnd_a = W'(p);
        opnd_b = W'(q);
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc   = 1;
        while (!done && cyc < MAXCYC) begin
            @(negedge clk);
            cyc++;
            if (cyc == poke) begin
                opnd_a = W'(6);
                opnd_b = W'(4);
                start  = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        logic [W-1:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 done after reset", int'(done), 0);
        check("R1 result after reset", int'(result), 0);

        for (int p = 0; p < (1 << W); p++) begin
            for (int q = 0; q < (1 << W); q++) begin
                run(p, q, 0, cyc);
                if (p == 0 || q == 0) begin
                    check("R4 zero-operand result", int'(result), (p == 0) ? q : p);
                    check("R4 zero-operand cycles", cyc, 2);
                end else begin
                    check("R2 R3 R6 gcd result", int'(result), ref_gcd(p, q));
                    check("R5 R9 cycle count", cyc, exp_cycles(p, q));
                end
                if (p == q || p == 0) begin
                    held = result;
                    repeat (3) @(negedge clk);
                    check("R8 done held", int'(done), 1);
                    check("R8 result held", int'(result), int'(held));
                end
            end
        end

        // R7: a start pulse in the middle of a long run is ignored
        run(15, 1, 5, cyc);
        check("R7 result unaffected", int'(result), 1);
        check("R7 cycles unaffected", cyc, exp_cycles(15, 1));
        run(9, 12, 4, cyc);
        check("R7 result unaffected second", int'(result), 3);
        check("R7 cycles unaffected second", cyc, exp_cycles(9, 12));

        // R1: reset while finished clears the outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 done after mid reset", int'(done), 0);
        check("R1 result after mid reset", int'(result), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule